// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

This block is an eight-stage storage register placed between two 8-bit buses, called A and B. One shared set of stages can copy a word from either bus toward the other, build a word from a serial bit stream and show it on either bus, keep its word by reloading itself, or take a word from a bus so that it can be shifted out bit by bit afterwards. Each bus is modelled as separate input, output and output-enable signals rather than true tri-state pins.

The block runs on a fast system clock. The register clock `reg_clk` is an ordinary input that is sampled on every system cycle, and its rising edge is found by comparing it with the previous sample. A parallel load is either tied to that edge or, when clock-independent loading is selected, repeats on every system cycle for as long as its conditions hold. Serial data enters stage 0 and moves one stage toward stage 7 per register-clock edge. Stage 7 is also available as a serial output.

Top module: `bsr_top`

## Requirements
- R1: While `rst_n` is low at a system clock edge, every stage is cleared to 0, whatever the mode inputs request.
- R2: With `par_sel` low, each rising edge of `reg_clk` moves stage i into stage i+1 and loads `ser_in` into stage 0 (bit 0 of the data outputs). Without a rising edge the stages hold.
- R3: With `par_sel` low, `async_sel` has no effect: the stages change only on rising `reg_clk` edges.
- R4: With `par_sel` high and `async_sel` low, the selected source word is loaded only on a rising `reg_clk` edge.
- R5: With `par_sel` high and `async_sel` high, the selected source word is loaded on every system clock cycle, with no `reg_clk` activity needed.
- R6: In parallel mode the source is `a_in` when `a_to_b` is high and `a_en` is high, and `b_in` when `a_to_b` is low, regardless of `a_en`.
- R7: In parallel mode with `a_to_b` high and `a_en` low, `a_in` is ignored and every stage reloads its own value, so the contents stay unchanged in both sync and async settings.
- R8: `b_oe` equals `a_to_b`, `a_oe` equals (not `a_to_b`) and `a_en`, and both `a_out` and `b_out` always carry the current stage contents.
- R9: `ser_out` carries stage 7, so a word loaded in parallel leaves most significant bit first when shifted.
- R10: Only a low-to-high change of `reg_clk` counts as an edge: holding it high for several system cycles gives one step, and a falling change gives none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_clk | input | 1 | Sampled register clock |
| a_en | input | 1 | A-side enable |
| async_sel | input | 1 | High: clock-independent parallel load |
| a_to_b | input | 1 | Direction: high means A is source and B is driven |
| par_sel | input | 1 | High: parallel mode; low: serial mode |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | A bus input data |
| b_in | input | 8 | B bus input data |
| a_out | output | 8 | A bus output data |
| a_oe | output | 1 | A bus output enable |
| b_out | output | 8 | B bus output data |
| b_oe | output | 1 | B bus output enable |
| ser_out | output | 1 | Stage 7 |

## Verification
Since both data outputs mirror the stages directly, a wrong stage value shows on `b_out` and `a_out` in the system cycle right after the faulty update, and a bad stage 7 shows on `ser_out` at the same time. A missed or doubled register-clock edge shows as a word shifted by one place too few or too many, which becomes visible after that same edge. A wrong source choice or a recirculation leak shows after a single load cycle, because the stored word then follows the wrong bus.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    parameter int unsigned BSR_STAGES = 8;

    typedef enum logic [1:0] {
        MODE_SHIFT      = 2'd0,
        MODE_LOAD_SYNC  = 2'd1,
        MODE_LOAD_ASYNC = 2'd2
    } bsr_mode_e;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_SELF = 2'd2
    } bsr_src_e;

endpackage

// File: rtl/bsr_edge_detect.sv
module bsr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);

    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= sig;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = rst_n & sig & ~st_q.prev;

endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic      par_sel,
    input  logic      async_sel,
    input  logic      a_to_b,
    input  logic      a_en,
    output bsr_mode_e mode,
    output bsr_src_e  src,
    output logic      a_oe,
    output logic      b_oe
);

    always_comb begin
        if (!par_sel) begin
            mode = MODE_SHIFT;
        end else if (async_sel) begin
            mode = MODE_LOAD_ASYNC;
        end else begin
            mode = MODE_LOAD_SYNC;
        end

        if (!a_to_b) begin
            src = SRC_B;
        end else if (a_en) begin
            src = SRC_A;
        end else begin
            src = SRC_SELF;
        end

        b_oe = a_to_b;
        a_oe = ~a_to_b & a_en;
    end

endmodule

// File: rtl/bsr_core.sv
module bsr_core
    import bsr_pkg::*;
#(
    parameter int unsigned STAGES = BSR_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  bsr_mode_e         mode,
    input  bsr_src_e          src,
    input  logic              ser_in,
    input  logic [STAGES-1:0] a_in,
    input  logic [STAGES-1:0] b_in,
    output logic [STAGES-1:0] stages,
    output logic              ser_out
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] word;
    } core_state_t;

    core_state_t       st_d, st_q;
    logic [STAGES-1:0] load_word;
    logic [STAGES-1:0] shift_word;

    always_comb begin
        unique case (src)
            SRC_A:   load_word = a_in;
            SRC_B:   load_word = b_in;
            default: load_word = st_q.word;
        endcase
    end

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_shift
            if (gi == 0) begin : g_head
                assign shift_word[gi] = ser_in;
            end else begin : g_body
                assign shift_word[gi] = st_q.word[gi-1];
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        unique case (mode)
            MODE_SHIFT: begin
                if (step) st_d.word = shift_word;
            end
            MODE_LOAD_SYNC: begin
                if (step) st_d.word = load_word;
            end
            MODE_LOAD_ASYNC: begin
                st_d.word = load_word;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages  = st_q.word;
    assign ser_out = st_q.word[LAST];

endmodule

// File: rtl/bsr_top.sv
module bsr_top
    import bsr_pkg::*;
#(
    parameter int unsigned STAGES = BSR_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_clk,
    input  logic              a_en,
    input  logic              async_sel,
    input  logic              a_to_b,
    input  logic              par_sel,
    input  logic              ser_in,
    input  logic [STAGES-1:0] a_in,
    input  logic [STAGES-1:0] b_in,
    output logic [STAGES-1:0] a_out,
    output logic              a_oe,
    output logic [STAGES-1:0] b_out,
    output logic              b_oe,
    output logic              ser_out
);

    logic              rclk_rise;
    bsr_mode_e         mode;
    bsr_src_e          src;
    logic [STAGES-1:0] stages;

    bsr_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (reg_clk),
        .rise  (rclk_rise)
    );

    bsr_ctrl u_ctrl (
        .par_sel   (par_sel),
        .async_sel (async_sel),
        .a_to_b    (a_to_b),
        .a_en      (a_en),
        .mode      (mode),
        .src       (src),
        .a_oe      (a_oe),
        .b_oe      (b_oe)
    );

    bsr_core #(.STAGES(STAGES)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (rclk_rise),
        .mode    (mode),
        .src     (src),
        .ser_in  (ser_in),
        .a_in    (a_in),
        .b_in    (b_in),
        .stages  (stages),
        .ser_out (ser_out)
    );

    assign a_out = stages;
    assign b_out = stages;

endmodule

// File: rtl/bsr_checks.sv
module bsr_checks #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rise,
    input logic              par_sel,
    input logic              async_sel,
    input logic              a_to_b,
    input logic              a_en,
    input logic              ser_in,
    input logic [STAGES-1:0] b_in,
    input logic [STAGES-1:0] b_out,
    input logic              a_oe,
    input logic              b_oe
);

    p_shift_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_sel && rise) |=> (b_out == {$past(b_out[STAGES-2:0]), $past(ser_in)}));

    p_serial_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_sel && !rise) |=> $stable(b_out));

    p_sync_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && !async_sel && !rise) |=> $stable(b_out));

    p_async_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && async_sel && !a_to_b) |=> (b_out == $past(b_in)));

    p_recirc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_sel && a_to_b && !a_en) |=> $stable(b_out));

    p_oe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe));

endmodule

bind bsr_top bsr_checks #(.STAGES(STAGES)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (rclk_rise),
    .par_sel   (par_sel),
    .async_sel (async_sel),
    .a_to_b    (a_to_b),
    .a_en      (a_en),
    .ser_in    (ser_in),
    .b_in      (b_in),
    .b_out     (b_out),
    .a_oe      (a_oe),
    .b_oe      (b_oe)
);

// File: tb/bsr_top_tb.sv
module bsr_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_clk = 1'b0;
    logic       a_en = 1'b0;
    logic       async_sel = 1'b0;
    logic       a_to_b = 1'b0;
    logic       par_sel = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe, ser_out;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    logic [7:0] model = 8'h00;
    logic       prev_rclk = 1'b0;
    bit         done = 0;

    always #10 clk = ~clk;

    bsr_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_clk(reg_clk), .a_en(a_en),
        .async_sel(async_sel), .a_to_b(a_to_b), .par_sel(par_sel),
        .ser_in(ser_in), .a_in(a_in), .b_in(b_in), .a_out(a_out),
        .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Behavioural reference: one system cycle.
    task automatic cyc();
        logic edge_seen;
        @(posedge clk);
        if (!rst_n) begin
            model = 8'h00;
        end else begin
            edge_seen = reg_clk && !prev_rclk;
            if (!par_sel) begin
                if (edge_seen) model = (model << 1) | {7'd0, ser_in};
            end else if (async_sel || edge_seen) begin
                if (!a_to_b)    model = b_in;
                else if (a_en)  model = a_in;
            end
        end
        prev_rclk = reg_clk;
        @(negedge clk);
        chk({cur_req, " b_out"}, b_out, model);
        chk({cur_req, " a_out"}, a_out, model);
        chk({cur_req, " ser_out"}, {7'd0, ser_out}, {7'd0, model[7]});
        chk("R8 b_oe", {7'd0, b_oe}, {7'd0, a_to_b});
        chk("R8 a_oe", {7'd0, a_oe}, {7'd0, !a_to_b && a_en});
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse();
        reg_clk = 1'b1; cycles(2);
        reg_clk = 1'b0; cycles(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset wins over an async load request
        cur_req = "R1";
        par_sel = 1; async_sel = 1; a_to_b = 0; b_in = 8'hFF;
        cycles(3);
        chk("R1 reset clear", b_out, 8'h00);
        par_sel = 0; async_sel = 0; a_to_b = 1; b_in = 8'h00;
        cyc();
        rst_n = 1;
        cycles(2);

        // R2: shift in A5, first bit ends up in stage 7
        cur_req = "R2";
        for (int k = 7; k >= 0; k--) begin
            ser_in = 1'(8'hA5 >> k);
            pulse();
        end
        chk("R2 serial word", b_out, 8'hA5);
        chk("R9 ser_out stage7", {7'd0, ser_out}, 8'h01);

        // R10: held high gives one step, falling gives none
        cur_req = "R10";
        ser_in = 0; reg_clk = 1; cycles(5);
        chk("R10 held high one step", b_out, 8'h4A);
        reg_clk = 0; cycles(3);
        chk("R10 falling no step", b_out, 8'h4A);

        // R3: async_sel ignored in serial mode
        cur_req = "R3";
        async_sel = 1; ser_in = 1; cycles(4);
        chk("R3 no edge no change", b_out, 8'h4A);
        pulse();
        chk("R3 edge shifts", b_out, 8'h95);
        async_sel = 0;

        // R4: sync load from B only on edge
        cur_req = "R4";
        par_sel = 1; a_to_b = 0; a_en = 1; b_in = 8'h3C;
        cycles(3);
        chk("R4 no edge no load", b_out, 8'h95);
        chk("R8 a_oe dir low en high", {7'd0, a_oe}, 8'h01);
        pulse();
        chk("R4 edge load B", b_out, 8'h3C);

        // R5: async load follows b_in every cycle
        cur_req = "R5";
        async_sel = 1; b_in = 8'hC3; cyc();
        chk("R5 async load", b_out, 8'hC3);
        b_in = 8'h77; cyc();
        chk("R5 async follows", b_out, 8'h77);
        a_en = 0; b_in = 8'h18; cyc();
        chk("R6 B source ignores a_en", b_out, 8'h18);
        async_sel = 0;

        // R6: A source with enable
        cur_req = "R6";
        a_to_b = 1; a_en = 1; a_in = 8'hE1; b_in = 8'h00;
        pulse();
        chk("R6 A source", b_out, 8'hE1);
        chk("R8 b_oe dir high", {7'd0, b_oe}, 8'h01);
        chk("R8 a_oe dir high", {7'd0, a_oe}, 8'h00);

        // R7: recirculation ignores A inputs
        cur_req = "R7";
        a_en = 0; a_in = 8'h00;
        pulse(); pulse();
        chk("R7 sync recirc", b_out, 8'hE1);
        async_sel = 1; a_in = 8'h5A; cycles(4);
        chk("R7 async recirc", b_out, 8'hE1);
        async_sel = 0;

        // R8: both enables off
        cur_req = "R8";
        a_to_b = 0; a_en = 0; cycles(2);
        chk("R8 a_oe off", {7'd0, a_oe}, 8'h00);
        chk("R8 b_oe off", {7'd0, b_oe}, 8'h00);

        // R9: parallel load then shift out MSB first
        cur_req = "R9";
        b_in = 8'hB2; pulse();
        chk("R9 loaded", b_out, 8'hB2);
        par_sel = 0; ser_in = 0; a_to_b = 1;
        for (int k = 1; k <= 8; k++) begin
            pulse();
            chk("R9 serial out bit", {7'd0, ser_out},
                (k == 8) ? 8'h00 : {7'd0, 1'(8'hB2 >> (7 - k))});
        end

        done = 1;
        finish_run();
    end

endmodule